// File: doc/BRIEF.md
# Prefix-Extending Instruction Decoder

This block turns one 16-bit instruction word per clock into the control fields that an execute stage needs: ALU operation and enable, source and destination register indices, a word-wide immediate, load/store strobes with a byte/word flag, and a branch strobe with its condition code. The outputs are registered. A decoded result appears on the clock edge after the word is offered with `in_valid` high.

The decoder keeps one piece of state: a prefix holder. An instruction with the prefix opcode stores its 12-bit payload. The next valid non-prefix instruction consumes that payload and merges it above its own short immediate, so wide constants can be built from two instructions. Without a pending prefix, short immediates are sign-extended (8-bit) or zero-extended (4-bit offsets) to the word width `WORD_W`.

Top module: `pfx_insn_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge leaves `dec_valid`, every strobe (`dec_reg_wr`, `dec_mem_rd`, `dec_mem_wr`, `dec_branch`, `dec_alu_en`, `dec_use_imm`) and `pfx_held` low.
- R2: `dec_valid` equals the `in_valid` of the previous cycle. When `in_valid` was low, `dec_reg_wr`, `dec_mem_rd`, `dec_mem_wr` and `dec_branch` are low.
- R3: Opcodes 0 to 7 (bits 15:12) are ALU operations with an 8-bit immediate. `dec_alu_fn` equals the opcode, and `dec_alu_en`, `dec_use_imm` and `dec_reg_wr` are high.
- R4: Opcode 10 is a register ALU operation. `dec_alu_fn` is bits 3:0, `dec_alu_en` and `dec_reg_wr` are high, `dec_use_imm` is low, and `dec_imm` is 0.
- R5: Opcodes 8 (byte) and 13 (word) are loads, with `dec_mem_rd` and `dec_reg_wr` high. Opcodes 9 (byte) and 14 (word) are stores, with `dec_mem_wr` high and `dec_reg_wr` low. `dec_mem_byte` is high only for 8 and 9. The offset is bits 3:0.
- R6: Opcode 11 is a branch. `dec_branch` is high, `dec_cond` is bits 11:8, `dec_imm` is the bits 7:0 displacement, and no register or memory write is requested. For all other opcodes `dec_cond` is 0.
- R7: Opcode 12 is a move immediate. `dec_reg_wr` and `dec_use_imm` are high and `dec_alu_en` is low.
- R8: With no prefix pending, the 8-bit immediate (bits 7:0) is sign-extended to `WORD_W`, and the 4-bit load/store offset is zero-extended.
- R9: Opcode 15 stores bits 11:0 as the prefix and sets `pfx_held` on the next edge. Its own decode has `dec_valid` high with no register write, memory access, branch or `dec_pfx_used`.
- R10: With a prefix P pending, the 8-bit immediate becomes (P<<8)|imm8 and the offset becomes (P<<4)|off4, each truncated to `WORD_W`. `dec_pfx_used` is high for that instruction.
- R11: Exactly one following valid non-prefix instruction of any opcode consumes the prefix and clears `pfx_held`. Idle cycles do not clear it.
- R12: A prefix that arrives while another is pending replaces the stored value. It does not accumulate with it.
- R13: Reset discards a pending prefix, so the first instruction after reset uses plain extension.
- Rx is always bits 11:8 (`dec_rx`) and Ry is always bits 7:4 (`dec_ry`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 16 | Instruction word |
| dec_valid | output | 1 | Decoded result present |
| dec_alu_en | output | 1 | Instruction uses the ALU |
| dec_alu_fn | output | 4 | ALU function code |
| dec_use_imm | output | 1 | Second operand is `dec_imm` |
| dec_reg_wr | output | 1 | Destination register write |
| dec_mem_rd | output | 1 | Memory load |
| dec_mem_wr | output | 1 | Memory store |
| dec_mem_byte | output | 1 | Memory access is byte sized |
| dec_branch | output | 1 | Branch instruction |
| dec_cond | output | 4 | Branch condition code |
| dec_rx | output | 4 | Register index from bits 11:8 |
| dec_ry | output | 4 | Register index from bits 7:4 |
| dec_imm | output | WORD_W | Extended or prefix-merged immediate |
| dec_pfx_used | output | 1 | Immediate was merged with a prefix |
| pfx_held | output | 1 | A prefix is pending |

## Verification
The bench builds two copies that share one input stream: `WORD_W`=16 and `WORD_W`=32. In the 16-bit copy a merged prefix loses its top four bits to truncation. The 32-bit copy shows the full 20-bit merge and sign-extension across a wider upper field. Running both against the same reference model shows that the prefix value, sign-extension and truncation scale with the parameter rather than being tied to one width.

// File: rtl/dec_pkg.sv
// Shared types for the prefix-extending instruction decoder.
// Assumes a 16-bit instruction word with the opcode in bits 15:12.
package dec_pkg;

    localparam int INSN_W = 16;
    localparam int PFX_W  = 12;
    localparam int IDX_W  = 4;

    typedef enum logic [3:0] {
        OP_ADDI = 4'd0,  OP_SUBI = 4'd1,  OP_ADCI = 4'd2,  OP_SBCI = 4'd3,
        OP_RSBI = 4'd4,  OP_ANDI = 4'd5,  OP_ORI  = 4'd6,  OP_XORI = 4'd7,
        OP_LDB  = 4'd8,  OP_STB  = 4'd9,  OP_ALUR = 4'd10, OP_BRC  = 4'd11,
        OP_MOVI = 4'd12, OP_LDW  = 4'd13, OP_STW  = 4'd14, OP_PFX  = 4'd15
    } opc_e;

    typedef enum logic [1:0] {
        IK_NONE   = 2'd0,
        IK_BYTE_S = 2'd1,
        IK_NIB_U  = 2'd2
    } imm_kind_e;

    typedef struct packed {
        logic        alu_en;
        logic [3:0]  alu_fn;
        logic        use_imm;
        logic        reg_wr;
        logic        mem_rd;
        logic        mem_wr;
        logic        mem_byte;
        logic        branch;
        logic [3:0]  cond;
        imm_kind_e   kind;
        logic        is_pfx;
    } ctrl_t;

endpackage

// File: rtl/dec_field_split.sv
// Combinational field splitter: classifies one instruction word and
// extracts its raw fields. It holds no state and assumes nothing about
// validity; the caller gates the strobes.
module dec_field_split
    import dec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output ctrl_t             ctrl,
    output logic [IDX_W-1:0]  rx,
    output logic [IDX_W-1:0]  ry,
    output logic [7:0]        imm8,
    output logic [3:0]        off4,
    output logic [PFX_W-1:0]  pfx12
);

    opc_e op;

    assign op    = opc_e'(insn[15:12]);
    assign rx    = insn[11:8];
    assign ry    = insn[7:4];
    assign imm8  = insn[7:0];
    assign off4  = insn[3:0];
    assign pfx12 = insn[PFX_W-1:0];

    // Purpose: derive control strobes and immediate kind from the opcode.
    always_comb begin
        ctrl = '0;
        unique case (op)
            OP_ADDI, OP_SUBI, OP_ADCI, OP_SBCI,
            OP_RSBI, OP_ANDI, OP_ORI, OP_XORI: begin
                ctrl.alu_en  = 1'b1;
                ctrl.alu_fn  = insn[15:12];
                ctrl.use_imm = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.kind    = IK_BYTE_S;
            end
            OP_ALUR: begin
                ctrl.alu_en = 1'b1;
                ctrl.alu_fn = insn[3:0];
                ctrl.reg_wr = 1'b1;
            end
            OP_LDB, OP_LDW: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.reg_wr   = 1'b1;
                ctrl.mem_byte = (op == OP_LDB);
                ctrl.kind     = IK_NIB_U;
            end
            OP_STB, OP_STW: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.mem_byte = (op == OP_STB);
                ctrl.kind     = IK_NIB_U;
            end
            OP_BRC: begin
                ctrl.branch = 1'b1;
                ctrl.cond   = insn[11:8];
                ctrl.kind   = IK_BYTE_S;
            end
            OP_MOVI: begin
                ctrl.use_imm = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.kind    = IK_BYTE_S;
            end
            OP_PFX: begin
                ctrl.is_pfx = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/dec_prefix_store.sv
// Prefix holder: stores a 12-bit payload when a prefix is accepted and
// drops it when one non-prefix instruction is accepted. Assumes load and
// consume are never high together.
module dec_prefix_store
    import dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             consume,
    input  logic [PFX_W-1:0] load_val,
    output logic             pend,
    output logic [PFX_W-1:0] val
);

    // Purpose: track the pending prefix; a new prefix overwrites the old one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            val  <= '0;
        end else if (load) begin
            pend <= 1'b1;
            val  <= load_val;
        end else if (consume) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/dec_imm_merge.sv
// Immediate builder: extends a short immediate to WORD_W or, with a
// prefix pending, places the prefix above it. Assumes WORD_W >= 16.
module dec_imm_merge
    import dec_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  imm_kind_e         kind,
    input  logic [7:0]        imm8,
    input  logic [3:0]        off4,
    input  logic              pend,
    input  logic [PFX_W-1:0]  pfx,
    output logic [WORD_W-1:0] imm
);

    localparam int SEXT_W = WORD_W - 8;

    // Purpose: select plain extension or the prefix merge for each kind.
    always_comb begin
        unique case (kind)
            IK_BYTE_S: imm = pend ? WORD_W'({pfx, imm8})
                                  : {{SEXT_W{imm8[7]}}, imm8};
            IK_NIB_U:  imm = pend ? WORD_W'({pfx, off4})
                                  : WORD_W'(off4);
            default:   imm = '0;
        endcase
    end

endmodule

// File: rtl/pfx_insn_decoder.sv
// Top level: one instruction per cycle in, registered decode out one
// cycle later. The prefix state is updated on the same edge that
// registers the decode of the consuming instruction.
module pfx_insn_decoder
    import dec_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       in_insn,
    output logic              dec_valid,
    output logic              dec_alu_en,
    output logic [3:0]        dec_alu_fn,
    output logic              dec_use_imm,
    output logic              dec_reg_wr,
    output logic              dec_mem_rd,
    output logic              dec_mem_wr,
    output logic              dec_mem_byte,
    output logic              dec_branch,
    output logic [3:0]        dec_cond,
    output logic [3:0]        dec_rx,
    output logic [3:0]        dec_ry,
    output logic [WORD_W-1:0] dec_imm,
    output logic              dec_pfx_used,
    output logic              pfx_held
);

    ctrl_t             ctrl;
    logic [IDX_W-1:0]  f_rx;
    logic [IDX_W-1:0]  f_ry;
    logic [7:0]        f_imm8;
    logic [3:0]        f_off4;
    logic [PFX_W-1:0]  f_pfx;
    logic [PFX_W-1:0]  held_val;
    logic [WORD_W-1:0] imm_next;
    logic              take_pfx;
    logic              take_insn;

    assign take_pfx  = in_valid &&  ctrl.is_pfx;
    assign take_insn = in_valid && !ctrl.is_pfx;

    dec_field_split u_split (
        .insn  (in_insn),
        .ctrl  (ctrl),
        .rx    (f_rx),
        .ry    (f_ry),
        .imm8  (f_imm8),
        .off4  (f_off4),
        .pfx12 (f_pfx)
    );

    dec_prefix_store u_pfx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_pfx),
        .consume  (take_insn),
        .load_val (f_pfx),
        .pend     (pfx_held),
        .val      (held_val)
    );

    dec_imm_merge #(.WORD_W(WORD_W)) u_imm (
        .kind (ctrl.kind),
        .imm8 (f_imm8),
        .off4 (f_off4),
        .pend (pfx_held),
        .pfx  (held_val),
        .imm  (imm_next)
    );

    // Purpose: register the decode; strobes are forced low on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid    <= 1'b0;
            dec_alu_en   <= 1'b0;
            dec_alu_fn   <= '0;
            dec_use_imm  <= 1'b0;
            dec_reg_wr   <= 1'b0;
            dec_mem_rd   <= 1'b0;
            dec_mem_wr   <= 1'b0;
            dec_mem_byte <= 1'b0;
            dec_branch   <= 1'b0;
            dec_cond     <= '0;
            dec_rx       <= '0;
            dec_ry       <= '0;
            dec_imm      <= '0;
            dec_pfx_used <= 1'b0;
        end else begin
            dec_valid    <= in_valid;
            dec_alu_fn   <= ctrl.alu_fn;
            dec_cond     <= ctrl.cond;
            dec_rx       <= f_rx;
            dec_ry       <= f_ry;
            dec_imm      <= imm_next;
            dec_mem_byte <= ctrl.mem_byte;
            dec_alu_en   <= in_valid && ctrl.alu_en;
            dec_use_imm  <= in_valid && ctrl.use_imm;
            dec_reg_wr   <= in_valid && ctrl.reg_wr;
            dec_mem_rd   <= in_valid && ctrl.mem_rd;
            dec_mem_wr   <= in_valid && ctrl.mem_wr;
            dec_branch   <= in_valid && ctrl.branch;
            dec_pfx_used <= take_insn && pfx_held;
        end
    end

endmodule

// File: rtl/pfx_insn_decoder_chk.sv
// Checker for the decoder's port behaviour, bound to every instance.
module pfx_insn_decoder_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [15:0]       in_insn,
    input logic              dec_valid,
    input logic              dec_use_imm,
    input logic              dec_reg_wr,
    input logic              dec_mem_rd,
    input logic              dec_mem_wr,
    input logic              dec_branch,
    input logic [WORD_W-1:0] dec_imm,
    input logic              dec_pfx_used,
    input logic              pfx_held
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dec_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!dec_valid && !dec_reg_wr && !dec_mem_rd && !dec_mem_wr && !dec_branch));

    assert_mem_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(dec_mem_rd && dec_mem_wr));

    assert_branch_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_branch |-> (!dec_reg_wr && !dec_mem_rd && !dec_mem_wr));

    assert_sign_extend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_use_imm && !dec_pfx_used)
            |-> (dec_imm[WORD_W-1:8] == {(WORD_W-8){dec_imm[7]}}));

    assert_prefix_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[15:12] == 4'hF)
            |=> (pfx_held && !dec_reg_wr && !dec_mem_rd && !dec_mem_wr && !dec_branch && !dec_pfx_used));

    assert_prefix_consumed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_held && in_valid && in_insn[15:12] != 4'hF) |=> (!pfx_held && dec_pfx_used));

    assert_prefix_survives_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_held && !in_valid) |=> pfx_held);

    assert_reset_clears_R13: assert property (@(posedge clk)
        !rst_n |=> (!pfx_held && !dec_valid));

endmodule

bind pfx_insn_decoder pfx_insn_decoder_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_insn      (in_insn),
    .dec_valid    (dec_valid),
    .dec_use_imm  (dec_use_imm),
    .dec_reg_wr   (dec_reg_wr),
    .dec_mem_rd   (dec_mem_rd),
    .dec_mem_wr   (dec_mem_wr),
    .dec_branch   (dec_branch),
    .dec_imm      (dec_imm),
    .dec_pfx_used (dec_pfx_used),
    .pfx_held     (pfx_held)
);

// File: tb/tb_pfx_insn_decoder.sv
module tb_pfx_insn_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int W_A = 16;
    localparam int W_B = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_insn = '0;

    logic a_valid, a_alu_en, a_use_imm, a_reg_wr, a_mem_rd, a_mem_wr, a_mem_byte, a_branch, a_pused, a_held;
    logic [3:0] a_fn, a_cond, a_rx, a_ry;
    logic [W_A-1:0] a_imm;
    logic b_valid, b_alu_en, b_use_imm, b_reg_wr, b_mem_rd, b_mem_wr, b_mem_byte, b_branch, b_pused, b_held;
    logic [3:0] b_fn, b_cond, b_rx, b_ry;
    logic [W_B-1:0] b_imm;

    int n_checks = 0;
    int n_errors = 0;
    bit m_pend = 1'b0;
    logic [11:0] m_pfx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfx_insn_decoder #(.WORD_W(W_A)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .dec_valid(a_valid), .dec_alu_en(a_alu_en), .dec_alu_fn(a_fn), .dec_use_imm(a_use_imm),
        .dec_reg_wr(a_reg_wr), .dec_mem_rd(a_mem_rd), .dec_mem_wr(a_mem_wr), .dec_mem_byte(a_mem_byte),
        .dec_branch(a_branch), .dec_cond(a_cond), .dec_rx(a_rx), .dec_ry(a_ry), .dec_imm(a_imm),
        .dec_pfx_used(a_pused), .pfx_held(a_held));

    pfx_insn_decoder #(.WORD_W(W_B)) dut_wide (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .dec_valid(b_valid), .dec_alu_en(b_alu_en), .dec_alu_fn(b_fn), .dec_use_imm(b_use_imm),
        .dec_reg_wr(b_reg_wr), .dec_mem_rd(b_mem_rd), .dec_mem_wr(b_mem_wr), .dec_mem_byte(b_mem_byte),
        .dec_branch(b_branch), .dec_cond(b_cond), .dec_rx(b_rx), .dec_ry(b_ry), .dec_imm(b_imm),
        .dec_pfx_used(b_pused), .pfx_held(b_held));

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference immediate, from the extension and merge rules (R8, R10).
    function automatic logic [63:0] ref_imm(input int w, input bit pend, input logic [11:0] p, input logic [15:0] i);
        logic [63:0] r;
        int op = int'(i[15:12]);
        if (op <= 7 || op == 11 || op == 12)
            r = pend ? ((64'(p) << 8) | 64'(i[7:0])) : {{56{i[7]}}, i[7:0]};
        else if (op == 8 || op == 9 || op == 13 || op == 14)
            r = pend ? ((64'(p) << 4) | 64'(i[3:0])) : 64'(i[3:0]);
        else
            r = '0;
        return r & ((64'd1 << w) - 64'd1);
    endfunction

    // Apply one cycle of input, advance the model, compare after the edge.
    task automatic step(input bit v, input logic [15:0] i, input string tag);
        int op = int'(i[15:12]);
        bit e_alu, e_uimm, e_wr, e_rd, e_st, e_byte, e_br, e_used;
        logic [3:0] e_fn, e_cond;
        logic [63:0] e_ia, e_ib;
        logic [25:0] e_vec, a_vec, b_vec;
        e_alu  = (op <= 7) || op == 10;
        e_fn   = (op <= 7) ? i[15:12] : (op == 10 ? i[3:0] : 4'd0);
        e_uimm = (op <= 7) || op == 12;
        e_wr   = (op <= 7) || op == 10 || op == 12 || op == 8 || op == 13;
        e_rd   = op == 8 || op == 13;
        e_st   = op == 9 || op == 14;
        e_byte = op == 8 || op == 9;
        e_br   = op == 11;
        e_cond = (op == 11) ? i[11:8] : 4'd0;
        e_used = m_pend && op != 15;
        e_ia   = ref_imm(W_A, m_pend, m_pfx, i);
        e_ib   = ref_imm(W_B, m_pend, m_pfx, i);
        if (v) begin
            if (op == 15) begin m_pend = 1'b1; m_pfx = i[11:0]; end
            else m_pend = 1'b0;
        end
        @(negedge clk);
        in_valid = v;
        in_insn  = i;
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (v) begin
            e_vec = {1'b1, e_alu, e_fn, e_uimm, e_wr, e_rd, e_st, e_byte, e_br, e_cond, i[11:8], i[7:4], e_used, m_pend};
            a_vec = {a_valid, a_alu_en, a_fn, a_use_imm, a_reg_wr, a_mem_rd, a_mem_wr, a_mem_byte, a_branch, a_cond, a_rx, a_ry, a_pused, a_held};
            b_vec = {b_valid, b_alu_en, b_fn, b_use_imm, b_reg_wr, b_mem_rd, b_mem_wr, b_mem_byte, b_branch, b_cond, b_rx, b_ry, b_pused, b_held};
            chk(tag, "ctrl w16", 64'(a_vec), 64'(e_vec));
            chk(tag, "ctrl w32", 64'(b_vec), 64'(e_vec));
            chk(tag, "imm w16", 64'(a_imm), e_ia);
            chk(tag, "imm w32", 64'(b_imm), e_ib);
        end else begin
            chk(tag, "idle w16", 64'({a_valid, a_reg_wr, a_mem_rd, a_mem_wr, a_branch, a_held}), 64'({5'b0, m_pend}));
            chk(tag, "idle w32", 64'({b_valid, b_reg_wr, b_mem_rd, b_mem_wr, b_branch, b_held}), 64'({5'b0, m_pend}));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        m_pend = 1'b0;
        chk("R1", "reset w16", 64'({a_valid, a_alu_en, a_use_imm, a_reg_wr, a_mem_rd, a_mem_wr, a_branch, a_held}), 64'd0);
        chk("R13", "reset w32", 64'({b_valid, b_alu_en, b_use_imm, b_reg_wr, b_mem_rd, b_mem_wr, b_branch, b_held}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R3: every ALU-immediate opcode, positive and negative immediates
        for (int k = 0; k < 8; k++) step(1'b1, {4'(k), 4'(k + 3), (k[0] ? 8'h9C : 8'h35)}, "R3");
        step(1'b1, 16'hA7C6, "R4");                  // register ALU, fn 6
        step(1'b1, 16'hA21F, "R4");                  // register ALU, fn 15
        step(1'b1, 16'h8349, "R5");                  // load byte
        step(1'b1, 16'h9A5F, "R5");                  // store byte
        step(1'b1, 16'hD1E2, "R5");                  // load word
        step(1'b1, 16'hE403, "R5");                  // store word
        step(1'b1, 16'hB3F0, "R6");                  // branch, negative displacement
        step(1'b1, 16'hBA12, "R6");                  // branch, positive displacement
        step(1'b1, 16'hC580, "R7");                  // move immediate, 0x80 sign-extends
        step(1'b1, 16'h0D7F, "R8");                  // largest positive imm8
        step(1'b0, 16'h1234, "R2");                  // idle, strobes low
        step(1'b1, 16'hFABC, "R9");                  // prefix 0xABC
        step(1'b1, 16'h025A, "R10");                 // merged: 0xBC5A / 0xABC5A
        step(1'b1, 16'h01FF, "R11");                 // prefix gone, plain sign-extend
        step(1'b1, 16'hF8F1, "R9");
        step(1'b0, 16'h0000, "R11");                 // idle keeps prefix
        step(1'b0, 16'h0000, "R11");
        step(1'b1, 16'hD247, "R10");                 // merged offset
        step(1'b1, 16'hF111, "R12");
        step(1'b1, 16'hF222, "R12");                 // replaces 0x111
        step(1'b1, 16'hC3FE, "R12");
        step(1'b1, 16'hF7FF, "R9");
        step(1'b1, 16'hA123, "R11");                 // register form consumes prefix
        step(1'b1, 16'h1190, "R11");
        step(1'b1, 16'hF555, "R13");
        do_reset();
        step(1'b1, 16'h6280, "R13");                 // no prefix after reset
        step(1'b1, 16'hF800, "R10");
        step(1'b1, 16'hB9F0, "R10");                 // merged branch displacement
        for (int k = 0; k < 600; k++) begin
            logic [15:0] w = 16'($urandom);
            if (($urandom % 5) == 0) w[15:12] = 4'hF;
            step(($urandom % 6) != 0, w, "R10");
        end
        summary();
        $finish;
    end

endmodule